// File: doc/BRIEF.md
# Instanced Attribute Index Unit

This unit turns the linear ID given to a dispatched vertex or compute thread into the element index used to fetch one vertex attribute. Each request carries the ID and the descriptor fields of the attribute: a two-bit mode, a five-bit shift, a three-bit extra-flags field and a 32-bit magic multiplier. Four mappings are offered. The ID can pass straight through, which is used when there is no instancing. It can be reduced modulo an odd factor of 1, 3, 5, 7 or 9 times a power of two, which gives per-vertex attributes under instancing. It can be shifted right when the divisor is a power of two. It can also be divided by an arbitrary constant, using a multiply by a reciprocal with an optional round-down correction and a final right shift.

Requests and results move over valid/ready handshakes through a two-stage pipeline. The first stage runs the odd-modulus reducer and the wide multiply. The second stage selects and shifts the result. A full pipeline holds two results while the consumer stalls.

Top module: `attr_index_unit`

## Requirements
- R1: While reset is asserted and right after it is released, out_valid is 0 and in_ready is 1.
- R2: Mode code 0 (direct) returns the ID unchanged.
- R3: Mode code 1 (modulo) returns id mod ((2·x+1)·2^s), where x is the extra-flags field (0 to 4) and s is the shift field.
- R4: Mode code 2 (power-of-two divide) returns id >> s.
- R5: Mode code 3 (magic divide) returns the upper 32 bits of id·M, shifted right by s, where M is the supplied multiplier. There is no shift of the ID before the multiply.
- R6: In mode 3, bit 31 of the supplied multiplier has no effect and is treated as 1.
- R7: In mode 3 with extra-flags equal to 1, the result is the upper 32 bits of (id+1)·M shifted right by s. The carry out of the low word is kept. Any other extra-flags value applies no correction.
- R8: For any divisor d, the constants give floor(id/d) for every 32-bit ID, including 2^32−1. The constants are s = floor(log2 d), m = ceil(2^(s+32)/d) and e = 2^(s+32) mod d. When e ≤ 2^s, the multiplier is m−1 with extra-flags 1; otherwise it is m with extra-flags 0.
- R9: A request is taken when in_valid and in_ready are both 1, and a result leaves when out_valid and out_ready are both 1. Results leave in request order, and out_index holds steady while out_valid is 1 and out_ready is 0.
- R10: With out_ready held at 0, the unit takes exactly two requests and then drops in_ready until a result leaves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_mode | input | 2 | 0 direct, 1 modulo, 2 power-of-two divide, 3 magic divide |
| in_shift | input | 5 | Shift field s |
| in_xflag | input | 3 | Extra-flags field (odd factor or round-down flag) |
| in_magic | input | 32 | Magic multiplier; bit 31 is implied |
| in_id | input | 32 | Linear thread ID |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_index | output | 32 | Attribute element index |

## Verification
Modulo mode is swept over every odd factor and all 32 shifts. Each setting uses IDs at zero, at the word edges and at random points, which separates errors in the kept low bits from errors in the reduced upper part. Magic divide is driven with constants derived for divisors 1 to 40 and for large or power-of-two divisors, at IDs d−1, d, d+1 and 2^32−1. These expose a wrong correction, a lost carry or a missing implied bit; the multiplier is sent with bit 31 alternately cleared and set. Arbitrary multipliers with extra-flags 0, 1 and 2 show that only the value 1 corrects. A stalled consumer shows the two-entry limit and that the output holds.

// File: rtl/attr_idx_pkg.sv
package attr_idx_pkg;
    localparam int ID_W  = 32;
    localparam int SH_W  = $clog2(ID_W);
    localparam int XF_W  = 3;
    localparam int REM_W = XF_W + 1;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_MODULO = 2'd1,
        MODE_POW2   = 2'd2,
        MODE_MAGIC  = 2'd3
    } mode_e;

    typedef struct packed {
        logic             valid;
        mode_e            mode;
        logic [SH_W-1:0]  shift;
        logic [ID_W-1:0]  id;
        logic [REM_W-1:0] rem;
        logic [ID_W-1:0]  mhi;
    } stage1_t;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] index;
    } stage2_t;
endpackage

// File: rtl/attr_odd_mod.sv
module attr_odd_mod #(
    parameter int W  = 32,
    parameter int KW = 4
) (
    input  logic [W-1:0]  value,
    input  logic [KW-1:0] k,
    output logic [KW-1:0] rem
);
    logic [KW:0] acc;

    always_comb begin
        acc = '0;
        for (int i = W - 1; i >= 0; i--) begin
            acc = {acc[KW-1:0], value[i]};
            if (acc >= {1'b0, k}) begin
                acc = acc - {1'b0, k};
            end
        end
        rem = acc[KW-1:0];
    end

    // R3: the remainder stays below the odd factor
    always_comb begin
        assert_rem_bound_R3: assert (k == '0 || rem < k)
            else $error("remainder %0d not below factor %0d", rem, k);
    end
endmodule

// File: rtl/attr_magic_mul.sv
module attr_magic_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0] id,
    input  logic [W-1:0] magic,
    input  logic         round_down,
    output logic [W-1:0] hi
);
    localparam int PW = 2 * W;

    logic [W-1:0]  mult;
    logic [PW-1:0] prod;
    logic [PW-1:0] sum;
    logic          unused_bits;

    assign mult        = {1'b1, magic[W-2:0]};
    assign prod        = PW'(id) * PW'(mult);
    assign sum         = prod + (round_down ? PW'(mult) : '0);
    assign hi          = sum[PW-1:W];
    assign unused_bits = ^{sum[W-1:0], magic[W-1]};

    // R7: adding the correction never wraps the double-width sum
    always_comb begin
        assert_no_wrap_R7: assert (sum >= prod)
            else $error("correction wrapped the product");
    end

    // R6: with the implied top bit the high word is at least half the id
    always_comb begin
        assert_top_bit_R6: assert (hi >= (id >> 1))
            else $error("implied multiplier bit missing");
    end
endmodule

// File: rtl/attr_index_unit.sv
module attr_index_unit
    import attr_idx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_mode,
    input  logic [SH_W-1:0]   in_shift,
    input  logic [XF_W-1:0]   in_xflag,
    input  logic [ID_W-1:0]   in_magic,
    input  logic [ID_W-1:0]   in_id,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ID_W-1:0]   out_index
);
    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;

    logic             adv2;
    logic [REM_W-1:0] odd_k;
    logic [REM_W-1:0] rem_w;
    logic [ID_W-1:0]  mhi_w;
    logic [ID_W-1:0]  hi_part;
    logic [ID_W-1:0]  low_mask;
    logic [ID_W-1:0]  result;

    assign odd_k   = {in_xflag, 1'b1};
    assign hi_part = in_id >> in_shift;

    attr_odd_mod #(.W(ID_W), .KW(REM_W)) u_mod (
        .value (hi_part),
        .k     (odd_k),
        .rem   (rem_w)
    );

    attr_magic_mul #(.W(ID_W)) u_mag (
        .id         (in_id),
        .magic      (in_magic),
        .round_down (in_xflag == XF_W'(1)),
        .hi         (mhi_w)
    );

    assign adv2      = !s2_q.valid || out_ready;
    assign in_ready  = !s1_q.valid || adv2;
    assign out_valid = s2_q.valid;
    assign out_index = s2_q.index;

    always_comb begin
        low_mask = (ID_W'(1) << s1_q.shift) - ID_W'(1);
        unique case (s1_q.mode)
            MODE_DIRECT: result = s1_q.id;
            MODE_MODULO: result = (ID_W'(s1_q.rem) << s1_q.shift) | (s1_q.id & low_mask);
            MODE_POW2:   result = s1_q.id >> s1_q.shift;
            default:     result = s1_q.mhi >> s1_q.shift;
        endcase
    end

    always_comb begin
        s1_d = s1_q;
        s2_d = s2_q;
        if (in_ready) begin
            s1_d.valid = in_valid;
            s1_d.mode  = mode_e'(in_mode);
            s1_d.shift = in_shift;
            s1_d.id    = in_id;
            s1_d.rem   = rem_w;
            s1_d.mhi   = mhi_w;
        end
        if (adv2) begin
            s2_d.valid = s1_q.valid;
            s2_d.index = result;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    // R9: a stalled result holds its value
    property p_hold;
        @(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_index));
    endproperty
    assert_hold_R9: assert property (p_hold);

    // R10: the input side closes only when both entries are stuck
    property p_full;
        @(posedge clk) disable iff (!rst_n)
        !in_ready |-> (out_valid && !out_ready);
    endproperty
    assert_full_R10: assert property (p_full);

    // R2: direct mode carries the id into the output register
    property p_direct;
        @(posedge clk) disable iff (!rst_n)
        (s1_q.valid && adv2 && s1_q.mode == MODE_DIRECT) |=> (out_index == $past(s1_q.id));
    endproperty
    assert_direct_R2: assert property (p_direct);

    // R3: modulo keeps the id bits below the shift
    property p_mod_low;
        @(posedge clk) disable iff (!rst_n)
        (s1_q.valid && adv2 && s1_q.mode == MODE_MODULO) |=>
            (((out_index ^ $past(s1_q.id)) & ((ID_W'(1) << $past(s1_q.shift)) - ID_W'(1))) == '0);
    endproperty
    assert_mod_low_R3: assert property (p_mod_low);
endmodule

// File: tb/attr_index_unit_test.sv
`timescale 1ns/1ps
module attr_index_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_mode = '0;
    logic [4:0]  in_shift = '0;
    logic [2:0]  in_xflag = '0;
    logic [31:0] in_magic = '0;
    logic [31:0] in_id = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_index;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit stall = 1'b0;
    bit done = 1'b0;
    logic [31:0] lcg = 32'h1ace_b00c;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] base_ids[8] = '{32'h0, 32'h1, 32'h2, 32'h3,
                                 32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff, 32'h1234_5678};

    always #10 clk = ~clk;

    attr_index_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .in_shift(in_shift), .in_xflag(in_xflag),
        .in_magic(in_magic), .in_id(in_id), .out_valid(out_valid),
        .out_ready(out_ready), .out_index(out_index)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    task automatic send(input logic [1:0] mode, input logic [4:0] sh, input logic [2:0] xf,
                        input logic [31:0] mg, input logic [31:0] id,
                        input logic [31:0] expv, input string tag);
        @(negedge clk);
        #1;
        in_mode = mode; in_shift = sh; in_xflag = xf; in_magic = mg; in_id = id;
        in_valid = 1'b1;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic magic_for(input logic [31:0] d, output logic [31:0] mg,
                             output logic [4:0] sh, output logic [2:0] xf);
        int s;
        logic [63:0] two, m, e;
        s = 0;
        while ((64'd1 << (s + 1)) <= {32'd0, d}) s++;
        two = 64'd1 << (s + 32);
        m = (two + {32'd0, d} - 64'd1) / {32'd0, d};
        e = two % {32'd0, d};
        sh = 5'(s);
        if (e <= (64'd1 << s)) begin
            mg = 32'(m - 64'd1);
            xf = 3'd1;
        end else begin
            mg = 32'(m);
            xf = 3'd0;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // output monitor: sets the consumer ready and compares leaving results
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            out_ready = stall ? 1'b0 : ((cyc % 4) != 3);
            #2;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected result", out_index, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_index == e, t, out_index, e);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 32'h0, 32'h0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] mg, id, held;
        logic [4:0]  sh;
        logic [2:0]  xf;
        logic [63:0] mm;
        logic [64:0] p;
        logic [31:0] mfull;
        logic [31:0] dlist[10] = '{32'd1000, 32'd12345, 32'd65535, 32'd65536, 32'd99999,
                                    32'h7fff_ffff, 32'h8000_0000, 32'hffff_ffff,
                                    32'd3 << 20, 32'd9 << 27};

        repeat (3) @(negedge clk);
        #3;
        check(out_valid == 1'b0, "R1 out_valid in reset", {31'd0, out_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        check(out_valid == 1'b0, "R1 out_valid after reset", {31'd0, out_valid}, 32'h0);
        check(in_ready == 1'b1, "R1 in_ready after reset", {31'd0, in_ready}, 32'h1);

        // R2 direct
        for (int i = 0; i < 8; i++) send(2'd0, 5'(i * 3), 3'(i), next_rand(), base_ids[i], base_ids[i], "R2 direct");
        for (int i = 0; i < 4; i++) begin
            id = next_rand();
            send(2'd0, 5'd7, 3'd2, 32'h0, id, id, "R2 direct");
        end

        // R3 modulo, every factor and shift
        for (int x = 0; x < 5; x++) begin
            for (int s = 0; s < 32; s++) begin
                mm = 64'(2 * x + 1) << s;
                for (int i = 0; i < 10; i++) begin
                    id = (i < 8) ? base_ids[i] : next_rand();
                    send(2'd1, 5'(s), 3'(x), 32'h0, id, 32'({32'd0, id} % mm), "R3 modulo");
                end
            end
        end

        // R4 power-of-two divide
        for (int s = 0; s < 32; s++) begin
            for (int i = 0; i < 10; i++) begin
                id = (i < 8) ? base_ids[i] : next_rand();
                send(2'd2, 5'(s), 3'd0, 32'h0, id, id >> s, "R4 shift divide");
            end
        end

        // R5 and R7 raw multiply with arbitrary multipliers and flags
        for (int j = 0; j < 3; j++) begin
            mg = (j == 0) ? 32'h0 : ((j == 1) ? 32'h1234_5678 : 32'hffff_ffff);
            mfull = {1'b1, mg[30:0]};
            for (int f = 0; f < 3; f++) begin
                for (int k = 0; k < 3; k++) begin
                    sh = (k == 0) ? 5'd0 : ((k == 1) ? 5'd5 : 5'd31);
                    for (int i = 0; i < 8; i++) begin
                        p = 65'(base_ids[i]) * 65'(mfull) + ((f == 1) ? 65'(mfull) : 65'd0);
                        send(2'd3, sh, 3'(f), mg, base_ids[i], 32'((p >> 32) >> sh),
                             (f == 1) ? "R7 round-down" : "R5 magic multiply");
                    end
                end
            end
        end

        // R8 divide by derived constants; R6 bit 31 cleared on alternate ids
        for (int n = 0; n < 50; n++) begin
            logic [31:0] d;
            d = (n < 40) ? 32'(n + 1) : dlist[n - 40];
            magic_for(d, mg, sh, xf);
            for (int i = 0; i < 13; i++) begin
                if (i < 8) id = base_ids[i];
                else if (i == 8) id = d - 32'd1;
                else if (i == 9) id = d;
                else if (i == 10) id = d + 32'd1;
                else id = next_rand();
                if (i[0]) send(2'd3, sh, xf, mg & 32'h7fff_ffff, id, id / d, "R6 bit31 cleared divide");
                else send(2'd3, sh, xf, mg, id, id / d, "R8 constant divide");
            end
        end

        // R10 and R9 stall behaviour
        repeat (6) @(negedge clk);
        stall = 1'b1;
        @(negedge clk);
        send(2'd2, 5'd4, 3'd0, 32'h0, 32'h0000_0abc, 32'h0000_00ab, "R9 order after stall");
        send(2'd0, 5'd0, 3'd0, 32'h0, 32'h5555_aaaa, 32'h5555_aaaa, "R9 order after stall");
        @(negedge clk);
        #3;
        check(in_ready == 1'b0, "R10 full with stall", {31'd0, in_ready}, 32'h0);
        check(out_valid == 1'b1, "R10 result waiting", {31'd0, out_valid}, 32'h1);
        held = out_index;
        repeat (3) @(negedge clk);
        #3;
        check(out_index == held, "R9 held output", out_index, held);
        check(in_ready == 1'b0, "R10 still full", {31'd0, in_ready}, 32'h0);
        stall = 1'b0;

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        #3;
        check(out_valid == 1'b0, "R9 drained", {31'd0, out_valid}, 32'h0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule